// File: doc/BRIEF.md
# Flash Controller Interrupt Status Unit

This unit is the register-side status keeper of a NAND-style flash controller. It owns a 16-bit interrupt status word that collects completion flags, a 16-bit controller status word that collects error flags, two 16-bit system configuration words, and the command word. A command engine (outside this block) reports the end of each operation through single-cycle strobes. Software reads the status and acknowledges events by writing to the interrupt status word.

The block drives one interrupt pin, whose active level software selects. It also drives a ready pin that software sets through the first configuration word. The block decides whether a command write is taken. While the interrupt pending bit is set, a new command is refused and the engine sees no start pulse.

Top module: `flash_irq_status_unit`

## Requirements
- R1: While `rst_ni` is low (cold reset), configuration 1 is 0x40C0, configuration 2 is 0x0000, controller status is 0x0000, interrupt status is 0x8080, the command word is 0x0000 and `rdy_o` is 1.
- R2: A cycle with `warm_rst_i` high loads interrupt status 0x8010 and returns configuration 1, configuration 2, controller status, the command word and `rdy_o` to their R1 values. It overrides every other input in that cycle.
- R3: A write to the interrupt status word (select 4) stores the current contents ANDed with the written value, so a written 0 clears that bit and a written 1 keeps it.
- R4: When the interrupt status word resulting from a write has bit 15 clear, status error bits 10 to 13 are cleared in the same cycle. While bit 15 stays set, the error bits are kept.
- R5: A load, program or erase completion strobe sets interrupt bit 15 together with its own done bit: bit 7 for load, bit 6 for program and bit 5 for erase. A generic done strobe sets only bit 15.
- R6: A completion strobe that arrives with `op_fail_i` high also sets status bit 10 and the operation's error bit: 13 for load, 12 for program and 11 for erase.
- R7: An unrecognised-command strobe sets status bit 10 and interrupt bit 15.
- R8: A write to the command word (select 0) is accepted only when interrupt bit 15 is clear. When it is accepted, `cmd_accept_o` is high in that cycle and the word is stored. When it is refused, the stored word is unchanged.
- R9: `irq_o` equals interrupt bit 15 XOR the inverse of configuration-1 bit 6: it is active high when bit 6 is 1 and active low when bit 6 is 0.
- R10: Reading configuration 1 (select 1) returns its value with bits 4:0 forced to 0. A write to configuration 1 makes `rdy_o` equal to written bit 7 from the next cycle.
- R11: When completion or error strobes arrive in the same cycle as an interrupt status write, the bits they set survive the write.
- R12: `rd_data_o` shows the word chosen by `reg_sel_i` combinationally: 0 command, 1 configuration 1, 2 configuration 2, 3 controller status, 4 interrupt status, and 0 for any other code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low cold reset, released synchronously |
| warm_rst_i | input | 1 | Synchronous warm reset pulse |
| reg_sel_i | input | 3 | Register select for reads and writes |
| reg_we_i | input | 1 | Register write enable |
| reg_wdata_i | input | 16 | Register write data |
| rd_data_o | output | 16 | Read data of the selected register |
| op_load_i | input | 1 | Load-complete strobe |
| op_prog_i | input | 1 | Program-complete strobe |
| op_erase_i | input | 1 | Erase-complete strobe |
| op_done_i | input | 1 | Generic command-complete strobe |
| op_bad_i | input | 1 | Unrecognised-command strobe |
| op_fail_i | input | 1 | Marks the completion in this cycle as failed |
| cmd_accept_o | output | 1 | High while a command write is being accepted |
| irq_o | output | 1 | Interrupt pin with programmable polarity |
| rdy_o | output | 1 | Ready pin |

## Verification
The bench builds the unit with its defaults: a 16-bit data path and a 3-bit select. With these values every flag position named in the requirements is reachable, and so is the unused select code 7. Both interrupt polarities are driven. Clear writes are made to coincide with failing completions, so priority and error retention can be observed on `rd_data_o` and `irq_o`.

// File: rtl/fisu_pkg.sv
package fisu_pkg;

  // interrupt status bit positions
  localparam int IRQ_PEND  = 15;
  localparam int IRQ_RST   = 4;
  localparam int IRQ_ERASE = 5;
  localparam int IRQ_PROG  = 6;
  localparam int IRQ_LOAD  = 7;

  // controller status error positions
  localparam int ERR_CMD   = 10;
  localparam int ERR_ERASE = 11;
  localparam int ERR_PROG  = 12;
  localparam int ERR_LOAD  = 13;

  // configuration-1 fields
  localparam int CFG_POL   = 6;
  localparam int CFG_RDY   = 7;
  localparam int CFG_HIDE  = 5;

  localparam logic [15:0] CFG1_INIT     = 16'h40C0;
  localparam logic [15:0] CFG2_INIT     = 16'h0000;
  localparam logic [15:0] IRQ_COLD_INIT = 16'h8080;
  localparam logic [15:0] IRQ_WARM_INIT = 16'h8010;

  // register select codes
  localparam int NUM_REGS = 5;
  localparam int SEL_CMD  = 0;
  localparam int SEL_CFG1 = 1;
  localparam int SEL_CFG2 = 2;
  localparam int SEL_STAT = 3;
  localparam int SEL_IRQ  = 4;

  // operation index: 0 load, 1 program, 2 erase
  localparam int NUM_OPS = 3;

  function automatic int op_done_pos(int k);
    case (k)
      0:       return IRQ_LOAD;
      1:       return IRQ_PROG;
      default: return IRQ_ERASE;
    endcase
  endfunction

  function automatic int op_err_pos(int k);
    case (k)
      0:       return ERR_LOAD;
      1:       return ERR_PROG;
      default: return ERR_ERASE;
    endcase
  endfunction

endpackage

// File: rtl/fisu_rst_sync.sv
module fisu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = chain_q[STAGES-1];

endmodule

// File: rtl/fisu_decode.sv
module fisu_decode #(
  parameter int SEL_W  = 3,
  parameter int N_REGS = 5
) (
  input  logic             we_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [N_REGS-1:0] hit_o
);

  for (genvar k = 0; k < N_REGS; k++) begin : g_hit
    assign hit_o[k] = we_i && (sel_i == SEL_W'(k));
  end

endmodule

// File: rtl/fisu_status_regs.sv
module fisu_status_regs
  import fisu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              warm_i,
  input  logic              we_irq_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NUM_OPS-1:0] op_i,
  input  logic              done_i,
  input  logic              bad_i,
  input  logic              fail_i,
  output logic [DATA_W-1:0] irq_q_o,
  output logic [DATA_W-1:0] stat_q_o
);

  localparam logic [DATA_W-1:0] ERR_MASK =
    DATA_W'((1 << ERR_CMD) | (1 << ERR_ERASE) | (1 << ERR_PROG) | (1 << ERR_LOAD));

  logic [DATA_W-1:0] irq_q, irq_d, stat_q, stat_d;
  logic [DATA_W-1:0] irq_set, stat_set, irq_kept;
  logic [NUM_OPS-1:0][DATA_W-1:0] op_irq_bits, op_err_bits;
  logic wipe, en;

  // per-operation set masks
  for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
    localparam logic [DATA_W-1:0] DONE_M =
      DATA_W'((1 << IRQ_PEND) | (1 << op_done_pos(k)));
    localparam logic [DATA_W-1:0] FAIL_M =
      DATA_W'((1 << ERR_CMD) | (1 << op_err_pos(k)));
    assign op_irq_bits[k] = op_i[k] ? DONE_M : '0;
    assign op_err_bits[k] = (op_i[k] && fail_i) ? FAIL_M : '0;
  end

  always_comb begin
    irq_set  = '0;
    stat_set = '0;
    for (int k = 0; k < NUM_OPS; k++) begin
      irq_set  = irq_set  | op_irq_bits[k];
      stat_set = stat_set | op_err_bits[k];
    end
    if (done_i) irq_set[IRQ_PEND] = 1'b1;
    if (bad_i) begin
      irq_set[IRQ_PEND] = 1'b1;
      stat_set[ERR_CMD] = 1'b1;
    end
  end

  // next state: clear write first, then event bits on top
  always_comb begin
    irq_kept = we_irq_i ? (irq_q & wdata_i) : irq_q;
    irq_d    = irq_kept | irq_set;
    wipe     = we_irq_i && !irq_d[IRQ_PEND];
    stat_d   = (wipe ? (stat_q & ~ERR_MASK) : stat_q) | stat_set;
    if (warm_i) begin
      irq_d  = DATA_W'(IRQ_WARM_INIT);
      stat_d = '0;
    end
    en = warm_i || we_irq_i || (|irq_set) || (|stat_set);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= DATA_W'(IRQ_COLD_INIT);
      stat_q <= '0;
    end else if (en) begin
      irq_q  <= irq_d;
      stat_q <= stat_d;
    end
  end

  assign irq_q_o  = irq_q;
  assign stat_q_o = stat_q;

endmodule

// File: rtl/fisu_cfg_regs.sv
module fisu_cfg_regs
  import fisu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              warm_i,
  input  logic              we_cmd_i,
  input  logic              we_cfg1_i,
  input  logic              we_cfg2_i,
  input  logic              pend_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] cmd_q_o,
  output logic [DATA_W-1:0] cfg1_q_o,
  output logic [DATA_W-1:0] cfg2_q_o,
  output logic              rdy_q_o,
  output logic              cmd_acc_o
);

  logic [DATA_W-1:0] cmd_q, cmd_d, cfg1_q, cfg1_d, cfg2_q, cfg2_d;
  logic rdy_q, rdy_d;
  logic cmd_en, cfg1_en, cfg2_en;

  assign cmd_acc_o = we_cmd_i && !pend_i && !warm_i;

  always_comb begin
    cmd_en  = warm_i || cmd_acc_o;
    cfg1_en = warm_i || we_cfg1_i;
    cfg2_en = warm_i || we_cfg2_i;
    cmd_d   = warm_i ? '0 : wdata_i;
    cfg1_d  = warm_i ? DATA_W'(CFG1_INIT) : wdata_i;
    cfg2_d  = warm_i ? DATA_W'(CFG2_INIT) : wdata_i;
    rdy_d   = warm_i ? 1'b1 : wdata_i[CFG_RDY];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmd_q <= '0;
    else if (cmd_en) cmd_q <= cmd_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg1_q <= DATA_W'(CFG1_INIT);
      rdy_q  <= 1'b1;
    end else if (cfg1_en) begin
      cfg1_q <= cfg1_d;
      rdy_q  <= rdy_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cfg2_q <= DATA_W'(CFG2_INIT);
    else if (cfg2_en) cfg2_q <= cfg2_d;
  end

  assign cmd_q_o  = cmd_q;
  assign cfg1_q_o = cfg1_q;
  assign cfg2_q_o = cfg2_q;
  assign rdy_q_o  = rdy_q;

endmodule

// File: rtl/flash_irq_status_unit.sv
module flash_irq_status_unit
  import fisu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              warm_rst_i,
  input  logic [SEL_W-1:0]  reg_sel_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              op_load_i,
  input  logic              op_prog_i,
  input  logic              op_erase_i,
  input  logic              op_done_i,
  input  logic              op_bad_i,
  input  logic              op_fail_i,
  output logic              cmd_accept_o,
  output logic              irq_o,
  output logic              rdy_o
);

  localparam logic [DATA_W-1:0] CFG1_RD_MASK = ~DATA_W'((1 << CFG_HIDE) - 1);

  logic rst_n;
  logic [NUM_REGS-1:0] hit;
  logic [DATA_W-1:0] irq_q, stat_q, cmd_q, cfg1_q, cfg2_q;

  fisu_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  fisu_decode #(.SEL_W(SEL_W), .N_REGS(NUM_REGS)) u_dec (
    .we_i  (reg_we_i),
    .sel_i (reg_sel_i),
    .hit_o (hit)
  );

  fisu_status_regs #(.DATA_W(DATA_W)) u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .warm_i   (warm_rst_i),
    .we_irq_i (hit[SEL_IRQ]),
    .wdata_i  (reg_wdata_i),
    .op_i     ({op_erase_i, op_prog_i, op_load_i}),
    .done_i   (op_done_i),
    .bad_i    (op_bad_i),
    .fail_i   (op_fail_i),
    .irq_q_o  (irq_q),
    .stat_q_o (stat_q)
  );

  fisu_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .warm_i    (warm_rst_i),
    .we_cmd_i  (hit[SEL_CMD]),
    .we_cfg1_i (hit[SEL_CFG1]),
    .we_cfg2_i (hit[SEL_CFG2]),
    .pend_i    (irq_q[IRQ_PEND]),
    .wdata_i   (reg_wdata_i),
    .cmd_q_o   (cmd_q),
    .cfg1_q_o  (cfg1_q),
    .cfg2_q_o  (cfg2_q),
    .rdy_q_o   (rdy_o),
    .cmd_acc_o (cmd_accept_o)
  );

  always_comb begin
    case (reg_sel_i)
      SEL_W'(SEL_CMD):  rd_data_o = cmd_q;
      SEL_W'(SEL_CFG1): rd_data_o = cfg1_q & CFG1_RD_MASK;
      SEL_W'(SEL_CFG2): rd_data_o = cfg2_q;
      SEL_W'(SEL_STAT): rd_data_o = stat_q;
      SEL_W'(SEL_IRQ):  rd_data_o = irq_q;
      default:          rd_data_o = '0;
    endcase
  end

  assign irq_o = irq_q[IRQ_PEND] ^ ~cfg1_q[CFG_POL];

endmodule

// File: rtl/fisu_chk.sv
module fisu_chk
  import fisu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 3
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              warm_rst_i,
  input logic [SEL_W-1:0]  reg_sel_i,
  input logic              reg_we_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              op_load_i,
  input logic              op_prog_i,
  input logic              op_erase_i,
  input logic              op_done_i,
  input logic              op_bad_i,
  input logic              op_fail_i,
  input logic              cmd_accept_o,
  input logic              rdy_o,
  input logic [DATA_W-1:0] irq_q,
  input logic [DATA_W-1:0] stat_q
);

  logic any_evt;
  assign any_evt = op_load_i | op_prog_i | op_erase_i | op_done_i | op_bad_i;

  // R8
  cmd_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (reg_we_i && reg_sel_i == SEL_W'(SEL_CMD) && irq_q[IRQ_PEND]) |-> !cmd_accept_o);

  // R5
  load_done_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (op_load_i && !warm_rst_i) |=> (irq_q[IRQ_PEND] && irq_q[IRQ_LOAD]));

  // R6
  prog_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (op_prog_i && op_fail_i && !warm_rst_i) |=> (stat_q[ERR_PROG] && stat_q[ERR_CMD]));

  // R4
  err_needs_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (|stat_q[ERR_LOAD:ERR_CMD]) |-> irq_q[IRQ_PEND]);

  // R3
  and_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (reg_we_i && reg_sel_i == SEL_W'(SEL_IRQ) && !any_evt && !warm_rst_i)
      |=> (irq_q == ($past(irq_q) & $past(reg_wdata_i))));

  // R10
  rdy_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (reg_we_i && reg_sel_i == SEL_W'(SEL_CFG1) && !warm_rst_i)
      |=> (rdy_o == $past(reg_wdata_i[CFG_RDY])));

endmodule

bind flash_irq_status_unit fisu_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) chk_i (
  .clk_i        (clk_i),
  .rst_n        (rst_n),
  .warm_rst_i   (warm_rst_i),
  .reg_sel_i    (reg_sel_i),
  .reg_we_i     (reg_we_i),
  .reg_wdata_i  (reg_wdata_i),
  .op_load_i    (op_load_i),
  .op_prog_i    (op_prog_i),
  .op_erase_i   (op_erase_i),
  .op_done_i    (op_done_i),
  .op_bad_i     (op_bad_i),
  .op_fail_i    (op_fail_i),
  .cmd_accept_o (cmd_accept_o),
  .rdy_o        (rdy_o),
  .irq_q        (irq_q),
  .stat_q       (stat_q)
);

// File: tb/flash_irq_status_unit_tb_top.sv
`timescale 1ns/1ps
module flash_irq_status_unit_tb_top;

  logic clk = 1'b0;
  logic rst_n;
  logic warm;
  logic [2:0] sel;
  logic we;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic ld, pg, er, dn, bad, fl;
  logic acc, irq, rdy;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  flash_irq_status_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .warm_rst_i(warm),
    .reg_sel_i(sel), .reg_we_i(we), .reg_wdata_i(wdata), .rd_data_o(rdata),
    .op_load_i(ld), .op_prog_i(pg), .op_erase_i(er), .op_done_i(dn),
    .op_bad_i(bad), .op_fail_i(fl),
    .cmd_accept_o(acc), .irq_o(irq), .rdy_o(rdy)
  );

  // {sel[3], we, wdata[16], {ld,pg,er,done,bad,fail}, exp_irq[16], exp_stat[16], exp_pin}
  localparam int NV = 18;
  localparam logic [58:0] VEC [NV] = '{
    {3'd4, 1'b1, 16'h0000, 6'b000000, 16'h0000, 16'h0000, 1'b0},
    {3'd0, 1'b0, 16'h0000, 6'b100000, 16'h8080, 16'h0000, 1'b1},
    {3'd4, 1'b1, 16'h7FFF, 6'b000000, 16'h0080, 16'h0000, 1'b0},
    {3'd0, 1'b0, 16'h0000, 6'b010001, 16'h80C0, 16'h1400, 1'b1},
    {3'd4, 1'b1, 16'hFFBF, 6'b000000, 16'h8080, 16'h1400, 1'b1},
    {3'd4, 1'b1, 16'h7FFF, 6'b000000, 16'h0080, 16'h0000, 1'b0},
    {3'd0, 1'b0, 16'h0000, 6'b001001, 16'h80A0, 16'h0C00, 1'b1},
    {3'd4, 1'b1, 16'h0000, 6'b100000, 16'h8080, 16'h0C00, 1'b1},
    {3'd4, 1'b1, 16'h0000, 6'b000000, 16'h0000, 16'h0000, 1'b0},
    {3'd0, 1'b0, 16'h0000, 6'b000010, 16'h8000, 16'h0400, 1'b1},
    {3'd4, 1'b1, 16'h0000, 6'b000000, 16'h0000, 16'h0000, 1'b0},
    {3'd0, 1'b0, 16'h0000, 6'b100001, 16'h8080, 16'h2400, 1'b1},
    {3'd4, 1'b1, 16'h0000, 6'b001001, 16'h8020, 16'h2C00, 1'b1},
    {3'd4, 1'b1, 16'h0000, 6'b000000, 16'h0000, 16'h0000, 1'b0},
    {3'd0, 1'b0, 16'h0000, 6'b000100, 16'h8000, 16'h0000, 1'b1},
    {3'd1, 1'b1, 16'h0000, 6'b000000, 16'h8000, 16'h0000, 1'b0},
    {3'd4, 1'b1, 16'h0000, 6'b000000, 16'h0000, 16'h0000, 1'b1},
    {3'd1, 1'b1, 16'h40C0, 6'b000000, 16'h0000, 16'h0000, 1'b0}
  };
  localparam string VTAG [NV] = '{
    "R3", "R5", "R3", "R6", "R4", "R4", "R6", "R11", "R4",
    "R7", "R4", "R6", "R11", "R4", "R5", "R9", "R9", "R9"
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  task automatic idle();
    we = 0; warm = 0; ld = 0; pg = 0; er = 0; dn = 0; bad = 0; fl = 0;
  endtask

  // apply for one edge, then release inputs just after it
  task automatic step(input logic [2:0] s, input logic w, input logic [15:0] d,
                      input logic [5:0] ev);
    @(negedge clk);
    sel = s; we = w; wdata = d;
    {ld, pg, er, dn, bad, fl} = ev;
    @(posedge clk);
    #1 idle();
  endtask

  task automatic peek(input logic [2:0] s, output logic [15:0] v);
    sel = s;
    #1 v = rdata;
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 0x%04h expected 0x%04h", 16'h0001, 16'h0000);
    finish_run();
  end

  initial begin
    logic [15:0] v;
    idle();
    sel = 0; wdata = 0; rst_n = 0;
    #12;
    // R1 reset state while held in reset
    peek(3'd1, v); check("R1 cfg1", v, 16'h40C0);
    peek(3'd2, v); check("R1 cfg2", v, 16'h0000);
    peek(3'd3, v); check("R1 stat", v, 16'h0000);
    peek(3'd4, v); check("R1 irq", v, 16'h8080);
    peek(3'd0, v); check("R1 cmd", v, 16'h0000);
    check("R1 rdy", {15'd0, rdy}, 16'h0001);
    check("R1 pin", {15'd0, irq}, 16'h0001);
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk);
    #1;

    // vector walk
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][58:56], VEC[i][55], VEC[i][54:39], VEC[i][38:33]);
      peek(3'd4, v); check({VTAG[i], " irq"}, v, VEC[i][32:17]);
      peek(3'd3, v); check({VTAG[i], " stat"}, v, VEC[i][16:1]);
      check({VTAG[i], " pin"}, {15'd0, irq}, {15'd0, VEC[i][0]});
    end

    // R8 command taken when not pending
    @(negedge clk);
    sel = 3'd0; we = 1; wdata = 16'h0094;
    #1 check("R8 accept", {15'd0, acc}, 16'h0001);
    @(posedge clk); #1 idle();
    peek(3'd0, v); check("R8 stored", v, 16'h0094);
    // R8 command refused while pending
    step(3'd0, 0, 16'h0000, 6'b000100);
    @(negedge clk);
    sel = 3'd0; we = 1; wdata = 16'h0080;
    #1 check("R8 refuse", {15'd0, acc}, 16'h0000);
    @(posedge clk); #1 idle();
    peek(3'd0, v); check("R8 unchanged", v, 16'h0094);

    // R10 read mask and ready pin
    step(3'd1, 1, 16'hFFFF, 6'b000000);
    peek(3'd1, v); check("R10 mask", v, 16'hFFE0);
    check("R10 rdy high", {15'd0, rdy}, 16'h0001);
    step(3'd1, 1, 16'h0040, 6'b000000);
    peek(3'd1, v); check("R10 plain", v, 16'h0040);
    check("R10 rdy low", {15'd0, rdy}, 16'h0000);

    // R12 config 2 and unused select
    step(3'd2, 1, 16'h1234, 6'b000000);
    peek(3'd2, v); check("R12 cfg2", v, 16'h1234);
    peek(3'd7, v); check("R12 unused", v, 16'h0000);

    // R2 warm reset after an error
    step(3'd0, 0, 16'h0000, 6'b000010);
    @(negedge clk); warm = 1; ld = 1; fl = 1;
    @(posedge clk); #1 idle();
    peek(3'd4, v); check("R2 irq", v, 16'h8010);
    peek(3'd3, v); check("R2 stat", v, 16'h0000);
    peek(3'd1, v); check("R2 cfg1", v, 16'h40C0);
    peek(3'd2, v); check("R2 cfg2", v, 16'h0000);
    peek(3'd0, v); check("R2 cmd", v, 16'h0000);
    check("R2 rdy", {15'd0, rdy}, 16'h0001);

    // R1 cold reset again asynchronously
    @(negedge clk); rst_n = 0;
    #1 peek(3'd4, v); check("R1 cold irq", v, 16'h8080);
    finish_run();
  end

endmodule